// File: doc/BRIEF.md
# Missing-Energy Vector Projection Presummer

This block takes twelve jet element transverse energies on every 40 MHz tick and forms three partial sums from them: the scalar total ET and the x and y components of the energy vector. Each jet element belongs to a fixed azimuthal bin. It is projected onto the two axes by multiplying it by constant cos φ and sin φ factors, which are set as parameters. Small contributions are suppressed by thresholds before the sum. The results are passed on to a later stage that combines partial sums from several such blocks.

The projection is exact to a quarter of a GeV. The fractional bits are kept through the whole twelve-way addition and dropped only once, at the end. A change in how channels are assigned to adders therefore cannot change the result. The outputs are clamped to a 4095 GeV ceiling. A jet element that arrives already saturated drives all three outputs to their ceilings.

Top module: `met_presum`

## Requirements
- R1: Each element's x (y) projection equals floor(ET × coef / 512) in quarter-GeV units. ET is the unsigned 10-bit jet element value in GeV. coef is the element's signed 12-bit cos (sin) factor with 11 fractional bits. Element k sits at bits [10k+9:10k] of `je_et`.
- R2: A projection whose magnitude is below EXY_THR quarter-GeV units (default 8) contributes zero to its sum.
- R3: A jet element below ET_THR GeV (default 2) contributes zero to `et_sum`.
- R4: The x and y projections of all twelve elements are added at full quarter-GeV precision. The total is then reduced once, by floor division by 4, to whole GeV.
- R5: `ex_sum` and `ey_sum` are two's-complement values clamped to the range −4095 to +4095.
- R6: `et_sum` is the thresholded sum of the jet element ETs, clamped to 4095.
- R7: If any jet element equals 1023, then `et_sum`, `ex_sum` and `ey_sum` all equal +4095.
- R8: Outputs reflect the inputs sampled two rising clock edges earlier. They are zero during reset and for the first two edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| je_et | input | 120 | Twelve 10-bit jet element ET values, element k at bits [10k+9:10k] |
| et_sum | output | 12 | Scalar ET partial sum in GeV |
| ex_sum | output | 14 | Signed x partial sum in GeV |
| ey_sum | output | 14 | Signed y partial sum in GeV |

## Verification
The bench uses inputs where each element's projection, truncated on its own, would lose a fraction. A design that rounded each element before the sum would come out one or more GeV low there. Negative projections check that a design does not round toward zero instead of flooring, and that thresholds are applied to the magnitude rather than to the signed value. A second instance with full-scale coefficients drives both signed sums past ±4095, so a wrong clamp or a wrapped sign shows up directly. A single saturated element among small ones catches a design that lets normal arithmetic through instead of forcing every output to its ceiling.

// File: rtl/met_pkg.sv
package met_pkg;

    // Default bin factors: twelve bins 30 degrees apart, starting at 15 degrees.
    // Values are cos/sin scaled by 2048 in 12-bit two's complement:
    // 1978 = 12'h7BA, 1448 = 12'h5A8, 530 = 12'h212,
    // -530 = 12'hDEE, -1448 = 12'hA58, -1978 = 12'h846. Element 0 is rightmost.
    localparam int DEF_N_JE   = 12;
    localparam int DEF_COEF_W = 12;

    localparam logic [DEF_N_JE*DEF_COEF_W-1:0] DEF_COS = {
        12'h7BA, 12'h5A8, 12'h212, 12'hDEE, 12'hA58, 12'h846,
        12'h846, 12'hA58, 12'hDEE, 12'h212, 12'h5A8, 12'h7BA
    };

    localparam logic [DEF_N_JE*DEF_COEF_W-1:0] DEF_SIN = {
        12'hDEE, 12'hA58, 12'h846, 12'h846, 12'hA58, 12'hDEE,
        12'h212, 12'h5A8, 12'h7BA, 12'h7BA, 12'h5A8, 12'h212
    };

endpackage

// File: rtl/met_projector.sv
// One axis projection of one jet element with magnitude threshold (R1, R2).
module met_projector #(
    parameter int ET_W   = 10,
    parameter int COEF_W = 12,
    parameter int SHIFT  = 9,
    parameter int PROJ_W = 14,
    parameter int THR    = 8
) (
    input  logic [ET_W-1:0]          et,
    input  logic signed [COEF_W-1:0] coef,
    output logic signed [PROJ_W-1:0] proj
);
    localparam int PROD_W = ET_W + 1 + COEF_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    logic signed [PROJ_W-1:0] raw;
    logic [PROJ_W-1:0]        mag;

    always_comb begin
        prod    = PROD_W'($signed({1'b0, et})) * PROD_W'(coef);
        shifted = prod >>> SHIFT;
        raw     = shifted[PROJ_W-1:0];
        mag     = raw[PROJ_W-1] ? $unsigned(-raw) : $unsigned(raw);
        proj    = (mag < PROJ_W'(THR)) ? '0 : raw;
    end
endmodule

// File: rtl/met_signed_presum.sv
// Full-precision signed sum, single floor truncation, symmetric clamp (R4, R5).
module met_signed_presum #(
    parameter int N     = 12,
    parameter int IN_W  = 14,
    parameter int DROP  = 2,
    parameter int OUT_W = 14,
    parameter int SAT   = 4095
) (
    input  logic signed [IN_W-1:0] terms [N],
    output logic signed [OUT_W-1:0] total
);
    localparam int SUM_W = IN_W + $clog2(N) + 1;
    localparam logic signed [SUM_W-1:0] HI = SUM_W'(SAT);
    localparam logic signed [SUM_W-1:0] LO = -HI;

    logic signed [SUM_W-1:0] acc;
    logic signed [SUM_W-1:0] trunc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < N; i++) begin
            acc = acc + SUM_W'(terms[i]);
        end
        trunc = acc >>> DROP;
        if (trunc > HI) begin
            total = OUT_W'(HI);
        end else if (trunc < LO) begin
            total = OUT_W'(LO);
        end else begin
            total = trunc[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/met_presum.sv
module met_presum
    import met_pkg::*;
#(
    parameter int N_JE      = DEF_N_JE,
    parameter int ET_W      = 10,
    parameter int COEF_W    = DEF_COEF_W,
    parameter int COEF_FRAC = 11,
    parameter int FRAC_BITS = 2,
    parameter int ET_THR    = 2,
    parameter int EXY_THR   = 8,
    parameter int ET_OUT_W  = 12,
    parameter int EXY_OUT_W = 14,
    parameter int SAT       = 4095,
    parameter logic [N_JE*COEF_W-1:0] COS_C = DEF_COS,
    parameter logic [N_JE*COEF_W-1:0] SIN_C = DEF_SIN
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_JE*ET_W-1:0]        je_et,
    output logic [ET_OUT_W-1:0]         et_sum,
    output logic signed [EXY_OUT_W-1:0] ex_sum,
    output logic signed [EXY_OUT_W-1:0] ey_sum
);
    localparam int SHIFT    = COEF_FRAC - FRAC_BITS;
    localparam int PROJ_W   = ET_W + 1 + COEF_W - SHIFT;
    localparam int ETSUM_W  = ET_W + $clog2(N_JE) + 1;
    localparam logic [ET_W-1:0]    ET_FULL = '1;
    localparam logic [ETSUM_W-1:0] ET_CEIL = ETSUM_W'(SAT);

    typedef struct packed {
        logic                               sat;
        logic [N_JE-1:0][ET_W-1:0]          et;
        logic [N_JE-1:0][PROJ_W-1:0]        ex;
        logic [N_JE-1:0][PROJ_W-1:0]        ey;
    } stage1_t;

    typedef struct packed {
        logic [ET_OUT_W-1:0]                et;
        logic [EXY_OUT_W-1:0]               ex;
        logic [EXY_OUT_W-1:0]               ey;
    } stage2_t;

    stage1_t s1_d, s1_q;
    stage2_t s2_d, s2_q;

    logic signed [PROJ_W-1:0]    px [N_JE];
    logic signed [PROJ_W-1:0]    py [N_JE];
    logic signed [PROJ_W-1:0]    qx [N_JE];
    logic signed [PROJ_W-1:0]    qy [N_JE];
    logic signed [EXY_OUT_W-1:0] sum_x;
    logic signed [EXY_OUT_W-1:0] sum_y;
    logic [ETSUM_W-1:0]          et_acc;

    for (genvar g = 0; g < N_JE; g++) begin : g_chan
        met_projector #(
            .ET_W(ET_W), .COEF_W(COEF_W), .SHIFT(SHIFT),
            .PROJ_W(PROJ_W), .THR(EXY_THR)
        ) u_px (
            .et  (je_et[g*ET_W +: ET_W]),
            .coef($signed(COS_C[g*COEF_W +: COEF_W])),
            .proj(px[g])
        );
        met_projector #(
            .ET_W(ET_W), .COEF_W(COEF_W), .SHIFT(SHIFT),
            .PROJ_W(PROJ_W), .THR(EXY_THR)
        ) u_py (
            .et  (je_et[g*ET_W +: ET_W]),
            .coef($signed(SIN_C[g*COEF_W +: COEF_W])),
            .proj(py[g])
        );
        assign qx[g] = $signed(s1_q.ex[g]);
        assign qy[g] = $signed(s1_q.ey[g]);
    end

    met_signed_presum #(
        .N(N_JE), .IN_W(PROJ_W), .DROP(FRAC_BITS),
        .OUT_W(EXY_OUT_W), .SAT(SAT)
    ) u_sum_x (
        .terms(qx),
        .total(sum_x)
    );

    met_signed_presum #(
        .N(N_JE), .IN_W(PROJ_W), .DROP(FRAC_BITS),
        .OUT_W(EXY_OUT_W), .SAT(SAT)
    ) u_sum_y (
        .terms(qy),
        .total(sum_y)
    );

    always_comb begin
        // stage 1: saturation detect, ET threshold, projections
        s1_d.sat = 1'b0;
        for (int i = 0; i < N_JE; i++) begin
            if (je_et[i*ET_W +: ET_W] == ET_FULL) begin
                s1_d.sat = 1'b1;
            end
            s1_d.et[i] = (je_et[i*ET_W +: ET_W] < ET_W'(ET_THR)) ? '0 : je_et[i*ET_W +: ET_W];
            s1_d.ex[i] = px[i];
            s1_d.ey[i] = py[i];
        end

        // stage 2: sums, clamps, saturation override
        et_acc = '0;
        for (int i = 0; i < N_JE; i++) begin
            et_acc = et_acc + ETSUM_W'(s1_q.et[i]);
        end
        if (s1_q.sat) begin
            s2_d.et = ET_OUT_W'(SAT);
            s2_d.ex = EXY_OUT_W'(SAT);
            s2_d.ey = EXY_OUT_W'(SAT);
        end else begin
            s2_d.et = (et_acc > ET_CEIL) ? ET_OUT_W'(SAT) : et_acc[ET_OUT_W-1:0];
            s2_d.ex = sum_x;
            s2_d.ey = sum_y;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign et_sum = s2_q.et;
    assign ex_sum = $signed(s2_q.ex);
    assign ey_sum = $signed(s2_q.ey);
endmodule

// File: rtl/met_presum_chk.sv
module met_presum_chk #(
    parameter int N_JE      = 12,
    parameter int ET_W      = 10,
    parameter int ET_THR    = 2,
    parameter int ET_OUT_W  = 12,
    parameter int EXY_OUT_W = 14,
    parameter int SAT       = 4095
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [N_JE*ET_W-1:0]        je_et,
    input logic [ET_OUT_W-1:0]         et_sum,
    input logic signed [EXY_OUT_W-1:0] ex_sum,
    input logic signed [EXY_OUT_W-1:0] ey_sum
);
    localparam logic signed [EXY_OUT_W-1:0] HI = EXY_OUT_W'(SAT);
    localparam logic signed [EXY_OUT_W-1:0] LO = -HI;

    logic [2:0] age;
    logic       any_full;
    logic       all_small;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 3'd7) begin
            age <= age + 3'd1;
        end
    end

    always_comb begin
        any_full  = 1'b0;
        all_small = 1'b1;
        for (int i = 0; i < N_JE; i++) begin
            if (&je_et[i*ET_W +: ET_W]) any_full = 1'b1;
            if (je_et[i*ET_W +: ET_W] >= ET_W'(ET_THR)) all_small = 1'b0;
        end
    end

    assert_signed_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_sum <= HI) && (ex_sum >= LO) && (ey_sum <= HI) && (ey_sum >= LO));

    assert_full_forces_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd2 && $past(any_full, 2)) |->
        (et_sum == ET_OUT_W'(SAT)) && (ex_sum == HI) && (ey_sum == HI));

    assert_zero_in_zero_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd2 && $past(je_et == '0, 2)) |->
        (et_sum == '0) && (ex_sum == '0) && (ey_sum == '0));

    assert_below_threshold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd2 && $past(all_small, 2)) |-> (et_sum == '0));

    assert_steady_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd5 && $past($stable(je_et), 2)) |->
        ($stable(et_sum) && $stable(ex_sum) && $stable(ey_sum)));
endmodule

bind met_presum met_presum_chk #(
    .N_JE(N_JE), .ET_W(ET_W), .ET_THR(ET_THR),
    .ET_OUT_W(ET_OUT_W), .EXY_OUT_W(EXY_OUT_W), .SAT(SAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .je_et(je_et),
    .et_sum(et_sum), .ex_sum(ex_sum), .ey_sum(ey_sum)
);

// File: tb/sim_met_presum.sv
module sim_met_presum;
    localparam int N  = 12;
    localparam int EW = 10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst_n;
    logic [N*EW-1:0]    je;
    logic [11:0]        et0, et1;
    logic signed [13:0] ex0, ey0, ex1, ey1;

    met_presum u0 (
        .clk(clk), .rst_n(rst_n), .je_et(je),
        .et_sum(et0), .ex_sum(ex0), .ey_sum(ey0)
    );

    met_presum #(
        .COS_C({N{12'h7FF}}),
        .SIN_C({N{12'h801}})
    ) u1 (
        .clk(clk), .rst_n(rst_n), .je_et(je),
        .et_sum(et1), .ex_sum(ex1), .ey_sum(ey1)
    );

    typedef struct {
        int    et;
        int    ex;
        int    ey;
        string tag;
    } exp_t;

    int   cos0[N] = '{1978, 1448, 530, -530, -1448, -1978, -1978, -1448, -530, 530, 1448, 1978};
    int   sin0[N] = '{530, 1448, 1978, 1978, 1448, 530, -530, -1448, -1978, -1978, -1448, -530};
    int   cos1[N];
    int   sin1[N];
    exp_t q0[$];
    exp_t q1[$];
    int   v[N];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    function automatic int clamp(int x);
        if (x > 4095) return 4095;
        if (x < -4095) return -4095;
        return x;
    endfunction

    function automatic exp_t model(int d[N], int cs[N], int sn[N], string tag);
        exp_t r;
        int sx, sy, st, p;
        bit full;
        sx = 0; sy = 0; st = 0; full = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (d[i] == 1023) full = 1'b1;
            p = (d[i] * cs[i]) >>> 9;
            if (p < 8 && p > -8) p = 0;
            sx += p;
            p = (d[i] * sn[i]) >>> 9;
            if (p < 8 && p > -8) p = 0;
            sy += p;
            st += (d[i] < 2) ? 0 : d[i];
        end
        r.tag = tag;
        if (full) begin
            r.et = 4095; r.ex = 4095; r.ey = 4095;
        end else begin
            r.et = (st > 4095) ? 4095 : st;
            r.ex = clamp(sx >>> 2);
            r.ey = clamp(sy >>> 2);
        end
        return r;
    endfunction

    task automatic compare(string inst, exp_t e, int a_et, int a_ex, int a_ey);
        checks++;
        if (a_et != e.et || a_ex != e.ex || a_ey != e.ey) begin
            errors++;
            $display("FAIL %s [%s]: et/ex/ey actual %0d/%0d/%0d expected %0d/%0d/%0d",
                     e.tag, inst, a_et, a_ex, a_ey, e.et, e.ex, e.ey);
        end
    endtask

    task automatic step(string tag);
        exp_t e;
        @(negedge clk);
        if (q0.size() >= 2) begin
            e = q0.pop_front();
            compare("u0", e, int'(et0), int'(ex0), int'(ey0));
            e = q1.pop_front();
            compare("u1", e, int'(et1), int'(ex1), int'(ey1));
        end
        for (int i = 0; i < N; i++) je[i*EW +: EW] = EW'(v[i]);
        q0.push_back(model(v, cos0, sin0, tag));
        q1.push_back(model(v, cos1, sin1, tag));
    endtask

    task automatic clear_v();
        for (int i = 0; i < N; i++) v[i] = 0;
    endtask

    initial begin
        exp_t z;
        int unsigned r;
        for (int i = 0; i < N; i++) begin
            cos1[i] = 2047;
            sin1[i] = -2047;
        end
        rst_n = 1'b0;
        je = '0;
        clear_v();
        repeat (3) @(negedge clk);
        z.et = 0; z.ex = 0; z.ey = 0; z.tag = "R8 reset";
        compare("u0", z, int'(et0), int'(ex0), int'(ey0));
        compare("u1", z, int'(et1), int'(ex1), int'(ey1));
        rst_n = 1'b1;
        q0.push_back(z); q0.push_back(z);
        q1.push_back(z); q1.push_back(z);

        clear_v(); step("R8 idle after reset");
        clear_v(); v[0] = 100; step("R1 single element");
        clear_v(); v[5] = 300; step("R1 negative projection floor");
        clear_v(); v[0] = 3; v[11] = 3; step("R4 single truncation after sum");
        clear_v(); v[2] = 5; step("R2 small x suppressed");
        clear_v(); v[3] = 5; step("R2 negative magnitude threshold");
        clear_v(); v[4] = 1; v[7] = 1; step("R3 ET below threshold");
        clear_v(); v[4] = 2; step("R3 ET at threshold");
        for (int i = 0; i < N; i++) v[i] = 400;
        step("R6 ET ceiling");
        for (int i = 0; i < N; i++) v[i] = 1022;
        step("R5 signed clamp");
        clear_v(); v[6] = 1023; v[1] = 10; step("R7 full element forces ceiling");
        clear_v(); v[9] = 1023; step("R7 full element alone");
        for (int i = 0; i < N; i++) v[i] = 900 - 70 * i;
        step("R8 back to back");
        step("R8 held input");
        clear_v(); step("R8 return to zero");

        r = 32'h1ACE_B00C;
        for (int c = 0; c < 300; c++) begin
            for (int i = 0; i < N; i++) begin
                r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
                v[i] = ((r & 32'hF) == 0) ? int'(r % 8) : int'(r % 1023);
            end
            if (c % 50 == 49) v[c % N] = 1023;
            step("R1 R2 R3 R4 R5 R6 R7 mixed");
        end
        clear_v();
        step("R8 flush");
        step("R8 flush");
        step("R8 flush");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule